// File: doc/BRIEF.md
# Flash Read Path With Status

This block forms the read side of a parallel NOR-style flash model. A separate command sequencer decides which mode the flash is in, and it passes that mode code to this block. Each accepted read strobe then returns one of four things, chosen by the mode: array bytes packed to the access width, identification words, bytes from the query table, or the status byte. The array itself lives outside the block. The block sends the access address out on `arr_addr_o` and receives four consecutive bytes back on `arr_rdata_i` in the same cycle.

The block also owns the 8-bit status register. The sequencer signals program writes, erase starts and erase completions to this block. The status register reacts to those events and to every status read: a read flips the toggle bit, and a completed erase inverts the polling bit. When an erase completes, the block reports back whether the sequencer should resume in the post-unlock state (bypass active) or in idle. A read under an undefined mode code also raises a request to the sequencer to reset its cycle state and latched command.

Top module: `flash_read_path`

## Requirements
- R1: `rd_valid_o` is high in exactly the cycle after an accepted `rd_en_i`. `rd_data_o` is registered and keeps its value until the next read.
- R2: In mode 0 (idle) and mode 1 (erase setup), the read returns array bytes starting at `rd_addr_i`, with the lowest address in bits 7:0. `rd_width_i` selects how many bytes: 00 gives one byte, 01 gives two bytes, 1x gives four bytes. Unused upper bytes are zero.
- R3: The word index used by modes 2 and 4 is `rd_addr_i[7:0]` shifted right by log2(`DEV_BYTES`).
- R4: In mode 2 (autoselect), the returned value depends on the word index:
  - Index 0 returns `ID0` and index 1 returns `ID1`.
  - Index 2 returns 0, meaning no sector is protected.
  - Index 0x0E returns `ID2` and index 0x0F returns `ID3`. If that word is 16'hFFFF, the read returns array data instead.
  - Every other index returns array data.
- R5: In mode 3 (operation busy), a read returns the status byte, zero-extended. That read then inverts status bit 6. Idle cycles do not change the status, and neither do reads in other modes.
- R6: `prog_wr_i` sets the status to {~`prog_bit7_i`, 7'h7F}. `erase_start_i` clears the status to 0. When events arrive in the same cycle, priority runs erase start, then program, then erase done, then the read toggle. A read in the same cycle as an event returns the status value from before the event.
- R7: `erase_done_i` inverts status bit 7. In the next cycle, `cmpl_valid_o` pulses high for one cycle. At the same time, `cmpl_bypass_o` carries `bypass_i`: 1 tells the sequencer to resume in the post-unlock state, and 0 tells it to return to idle.
- R8: In mode 4 (query), a word index below `CFI_LEN` (0x52) returns the table byte, zero-extended. An index at or above `CFI_LEN` returns 0.
- R9: The query table holds:
  - 0x51, 0x52, 0x59 ("QRY") at indices 0x10, 0x11 and 0x12;
  - 0x02 at 0x13 and 0x31 at 0x15;
  - log2(`ARRAY_BYTES`) at 0x27;
  - 0x01 at 0x2C;
  - 0 at every other index.
- R10: A read under mode codes 5 to 7 returns array data as in R2. Alongside `rd_valid_o`, it raises `mode_reset_o` for one cycle. Reads in modes 0 to 4 never raise it.
- R11: After reset, the status is 0, and `rd_valid_o`, `rd_data_o`, `mode_reset_o` and `cmpl_valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Mode code from the command sequencer |
| bypass_i | input | 1 | Bypass mode is active in the sequencer |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Byte address of the read |
| rd_width_i | input | 2 | Access width code |
| arr_addr_o | output | ADDR_W | Address sent to the array |
| arr_rdata_i | input | 32 | Four array bytes starting at `arr_addr_o` |
| prog_wr_i | input | 1 | A program write was taken |
| prog_bit7_i | input | 1 | Bit 7 of the programmed data |
| erase_start_i | input | 1 | An erase begins |
| erase_done_i | input | 1 | The erase in progress completes |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| mode_reset_o | output | 1 | Request to reset the sequencer after a read under an undefined mode |
| cmpl_valid_o | output | 1 | Erase completion pulse |
| cmpl_bypass_o | output | 1 | Resume target for the sequencer: 1 for post-unlock, 0 for idle |

## Verification
The sweeps cover every byte address at every access width. A design that packs the bytes in the wrong order, or leaves upper bytes unmasked, fails here. Identification indices 0x0E and 0x0F are swept with one word configured and one word left at all ones. A design that returns 16'hFFFF instead of falling back to array data fails here. The query sweep crosses the length limit at 0x52, which catches an off-by-one that leaks table bytes. Status sequences interleave reads, idle gaps, reads in other modes and coincident events. A toggle that fires on idle cycles, or on reads in other modes, shifts every later status value. So does a read that returns the value after the event instead of before it.

// File: rtl/frp_pkg.sv
package frp_pkg;
    typedef enum logic [2:0] {
        MD_IDLE    = 3'd0,
        MD_ERSETUP = 3'd1,
        MD_AUTOSEL = 3'd2,
        MD_BUSY    = 3'd3,
        MD_QUERY   = 3'd4
    } frp_mode_e;

    localparam logic [7:0] ST_PROG_LOW = 8'h7F;
    localparam logic [7:0] ST_TOGGLE   = 8'h40;
    localparam logic [7:0] ST_POLL     = 8'h80;
endpackage

// File: rtl/frp_array_pack.sv
module frp_array_pack #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] raw_i,
    input  logic [1:0]        width_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int NB = DATA_W / 8;

    logic [3:0] nbytes;

    always_comb begin
        unique case (width_i)
            2'b00:   nbytes = 4'd1;
            2'b01:   nbytes = 4'd2;
            default: nbytes = 4'd4;
        endcase
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign data_o[i*8 +: 8] = (4'(i) < nbytes) ? raw_i[i*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/frp_query_rom.sv
module frp_query_rom #(
    parameter int TBL_LEN   = 82,
    parameter int SIZE_LOG2 = 12
) (
    input  logic [7:0] idx_i,
    output logic [7:0] byte_o
);
    always_comb begin
        byte_o = 8'h00;
        if (int'(idx_i) < TBL_LEN) begin
            unique case (idx_i)
                8'h10:   byte_o = 8'h51;
                8'h11:   byte_o = 8'h52;
                8'h12:   byte_o = 8'h59;
                8'h13:   byte_o = 8'h02;
                8'h15:   byte_o = 8'h31;
                8'h27:   byte_o = 8'(SIZE_LOG2);
                8'h2C:   byte_o = 8'h01;
                default: byte_o = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/frp_status.sv
module frp_status
    import frp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_hit_i,
    input  logic       prog_wr_i,
    input  logic       prog_bit7_i,
    input  logic       erase_start_i,
    input  logic       erase_done_i,
    output logic [7:0] status_o
);
    logic [7:0] status_q, status_d;

    always_comb begin
        status_d = status_q;
        if (erase_start_i)
            status_d = 8'h00;
        else if (prog_wr_i)
            status_d = {~prog_bit7_i, ST_PROG_LOW[6:0]};
        else if (erase_done_i)
            status_d = status_q ^ ST_POLL;
        else if (rd_hit_i)
            status_d = status_q ^ ST_TOGGLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= 8'h00;
        else        status_q <= status_d;
    end

    assign status_o = status_q;
endmodule

// File: rtl/flash_read_path.sv
module flash_read_path
    import frp_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter int          DEV_BYTES   = 2,
    parameter int          ARRAY_BYTES = 4096,
    parameter int          CFI_LEN     = 82,
    parameter logic [15:0] ID0         = 16'h0001,
    parameter logic [15:0] ID1         = 16'h227E,
    parameter logic [15:0] ID2         = 16'h2222,
    parameter logic [15:0] ID3         = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic              bypass_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [1:0]        rd_width_i,
    output logic [ADDR_W-1:0] arr_addr_o,
    input  logic [31:0]       arr_rdata_i,
    input  logic              prog_wr_i,
    input  logic              prog_bit7_i,
    input  logic              erase_start_i,
    input  logic              erase_done_i,
    output logic              rd_valid_o,
    output logic [31:0]       rd_data_o,
    output logic              mode_reset_o,
    output logic              cmpl_valid_o,
    output logic              cmpl_bypass_o
);
    localparam int SHIFT     = (DEV_BYTES >= 4) ? 2 : ((DEV_BYTES == 2) ? 1 : 0);
    localparam int SIZE_LOG2 = $clog2(ARRAY_BYTES);

    frp_mode_e   mode_e;
    logic [7:0]  word_addr;
    logic [31:0] arr_word;
    logic [7:0]  query_byte;
    logic [7:0]  status_q;
    logic [31:0] nxt_data;
    logic        busy_read;
    logic        bad_mode;

    logic        rd_valid_q, mode_reset_q, cmpl_valid_q, cmpl_bypass_q;
    logic [31:0] rd_data_q;

    assign mode_e     = frp_mode_e'(mode_i);
    assign word_addr  = rd_addr_i[7:0] >> SHIFT;
    assign arr_addr_o = rd_addr_i;

    frp_array_pack #(.DATA_W(32)) u_pack (
        .raw_i   (arr_rdata_i),
        .width_i (rd_width_i),
        .data_o  (arr_word)
    );

    frp_query_rom #(.TBL_LEN(CFI_LEN), .SIZE_LOG2(SIZE_LOG2)) u_rom (
        .idx_i  (word_addr),
        .byte_o (query_byte)
    );

    frp_status u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_hit_i      (busy_read),
        .prog_wr_i     (prog_wr_i),
        .prog_bit7_i   (prog_bit7_i),
        .erase_start_i (erase_start_i),
        .erase_done_i  (erase_done_i),
        .status_o      (status_q)
    );

    // Source selection by mode
    always_comb begin
        nxt_data  = arr_word;
        busy_read = 1'b0;
        bad_mode  = 1'b0;
        unique case (mode_e)
            MD_IDLE, MD_ERSETUP: nxt_data = arr_word;
            MD_AUTOSEL: begin
                unique case (word_addr)
                    8'h00:   nxt_data = {16'h0, ID0};
                    8'h01:   nxt_data = {16'h0, ID1};
                    8'h02:   nxt_data = 32'h0;
                    8'h0E:   nxt_data = (ID2 == 16'hFFFF) ? arr_word : {16'h0, ID2};
                    8'h0F:   nxt_data = (ID3 == 16'hFFFF) ? arr_word : {16'h0, ID3};
                    default: nxt_data = arr_word;
                endcase
            end
            MD_BUSY: begin
                nxt_data  = {24'h0, status_q};
                busy_read = rd_en_i;
            end
            MD_QUERY: nxt_data = {24'h0, query_byte};
            default: begin
                nxt_data = arr_word;
                bad_mode = 1'b1;
            end
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_q    <= 1'b0;
            rd_data_q     <= 32'h0;
            mode_reset_q  <= 1'b0;
            cmpl_valid_q  <= 1'b0;
            cmpl_bypass_q <= 1'b0;
        end else begin
            rd_valid_q    <= rd_en_i;
            if (rd_en_i) rd_data_q <= nxt_data;
            mode_reset_q  <= rd_en_i & bad_mode;
            cmpl_valid_q  <= erase_done_i;
            cmpl_bypass_q <= erase_done_i & bypass_i;
        end
    end

    assign rd_valid_o    = rd_valid_q;
    assign rd_data_o     = rd_data_q;
    assign mode_reset_o  = mode_reset_q;
    assign cmpl_valid_o  = cmpl_valid_q;
    assign cmpl_bypass_o = cmpl_bypass_q;
endmodule

// File: rtl/frp_checker.sv
module frp_checker #(
    parameter int ADDR_W    = 12,
    parameter int DEV_BYTES = 2,
    parameter int CFI_LEN   = 82
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mode_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic              prog_wr_i,
    input logic              prog_bit7_i,
    input logic              erase_start_i,
    input logic              erase_done_i,
    input logic              rd_valid_o,
    input logic [31:0]       rd_data_o,
    input logic              mode_reset_o,
    input logic              cmpl_valid_o,
    input logic [7:0]        status_q
);
    localparam int SHIFT = (DEV_BYTES >= 4) ? 2 : ((DEV_BYTES == 2) ? 1 : 0);

    logic [7:0] widx;
    logic       any_evt;
    logic       busy_rd;
    assign widx    = rd_addr_i[7:0] >> SHIFT;
    assign any_evt = prog_wr_i | erase_start_i | erase_done_i;
    assign busy_rd = rd_en_i && (mode_i == 3'd3);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o); // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_o); // R1
    AST_STATUS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_rd && !any_evt) |=> (status_q == ($past(status_q) ^ 8'h40))); // R5
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_rd && !any_evt) |=> $stable(status_q)); // R5
    AST_ERASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start_i |=> (status_q == 8'h00)); // R6
    AST_PROG_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_wr_i && !erase_start_i) |=> (status_q == {~$past(prog_bit7_i), 7'h7F})); // R6
    AST_POLL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_done_i && !erase_start_i && !prog_wr_i) |=> (status_q[7] != $past(status_q[7]))); // R7
    AST_CMPL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done_i |=> cmpl_valid_o); // R7
    AST_QUERY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && mode_i == 3'd4 && int'(widx) >= CFI_LEN) |=> (rd_data_o == 32'h0)); // R8
    AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && mode_i > 3'd4) |=> mode_reset_o); // R10
    AST_NO_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i && mode_i > 3'd4) |=> !mode_reset_o); // R10
endmodule

bind flash_read_path frp_checker #(
    .ADDR_W(ADDR_W), .DEV_BYTES(DEV_BYTES), .CFI_LEN(CFI_LEN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .rd_en_i       (rd_en_i),
    .rd_addr_i     (rd_addr_i),
    .prog_wr_i     (prog_wr_i),
    .prog_bit7_i   (prog_bit7_i),
    .erase_start_i (erase_start_i),
    .erase_done_i  (erase_done_i),
    .rd_valid_o    (rd_valid_o),
    .rd_data_o     (rd_data_o),
    .mode_reset_o  (mode_reset_o),
    .cmpl_valid_o  (cmpl_valid_o),
    .status_q      (status_q)
);

// File: tb/tb_flash_read_path.sv
module tb_flash_read_path;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        mode_i = 3'd0;
    logic              bypass_i = 1'b0;
    logic              rd_en_i = 1'b0;
    logic [ADDR_W-1:0] rd_addr_i = '0;
    logic [1:0]        rd_width_i = 2'b00;
    logic [ADDR_W-1:0] arr_addr_o;
    logic [31:0]       arr_rdata_i;
    logic              prog_wr_i = 1'b0, prog_bit7_i = 1'b0;
    logic              erase_start_i = 1'b0, erase_done_i = 1'b0;
    logic              rd_valid_o;
    logic [31:0]       rd_data_o;
    logic              mode_reset_o, cmpl_valid_o, cmpl_bypass_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [7:0] st;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_read_path dut (.*);

    function automatic logic [7:0] mb(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    assign arr_rdata_i = {mb(int'(arr_addr_o) + 3), mb(int'(arr_addr_o) + 2),
                          mb(int'(arr_addr_o) + 1), mb(int'(arr_addr_o))};

    function automatic logic [31:0] arr_exp(input int a, input int w);
        logic [31:0] v;
        v = {24'h0, mb(a)};
        if (w >= 1) v[15:8] = mb(a + 1);
        if (w >= 2) v[31:16] = {mb(a + 3), mb(a + 2)};
        return v;
    endfunction

    function automatic logic [7:0] query_exp(input int wi);
        if (wi >= 82) return 8'h00;
        case (wi)
            16: return 8'h51;
            17: return 8'h52;
            18: return 8'h59;
            19: return 8'h02;
            21: return 8'h31;
            39: return 8'd12;
            44: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic rd(input int md, input int a, input int w);
        @(negedge clk);
        mode_i = 3'(md); rd_addr_i = ADDR_W'(a); rd_width_i = 2'(w); rd_en_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic evt(input bit ps, input bit pb, input bit es, input bit ed, input bit by);
        @(negedge clk);
        prog_wr_i = ps; prog_bit7_i = pb; erase_start_i = es; erase_done_i = ed; bypass_i = by;
        @(posedge clk);
        @(negedge clk);
        prog_wr_i = 0; erase_start_i = 0; erase_done_i = 0; bypass_i = 0;
    endtask

    task automatic status_rd(input string req);
        rd(3, 0, 0);
        chk(req, rd_data_o, {24'h0, st});
        st = st ^ 8'h40;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 rd_valid", {31'h0, rd_valid_o}, 0);
        chk("R11 rd_data", rd_data_o, 0);
        chk("R11 mode_reset", {31'h0, mode_reset_o}, 0);
        chk("R11 cmpl_valid", {31'h0, cmpl_valid_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        st = 8'h00;
        status_rd("R11 status after reset");

        // R2 array sweep in idle and erase-setup modes, all widths
        for (int w = 0; w < 3; w++)
            for (int a = 0; a < 256; a++) begin
                rd((a % 2 == 0) ? 0 : 1, a, w);
                chk("R2 array data", rd_data_o, arr_exp(a, w));
                chk("R1 valid after strobe", {31'h0, rd_valid_o}, 1);
            end
        @(negedge clk);
        chk("R1 no valid without strobe", {31'h0, rd_valid_o}, 0);
        chk("R1 data held", rd_data_o, arr_exp(255, 2));

        // R3/R4 autoselect sweep (DEV_BYTES=2: byte address = index*2)
        for (int wi = 0; wi < 128; wi++) begin
            logic [31:0] e;
            rd(2, wi * 2, 1);
            case (wi)
                0: e = 32'h0001;
                1: e = 32'h227E;
                2: e = 32'h0;
                14: e = 32'h2222;
                default: e = arr_exp(wi * 2, 1);
            endcase
            chk("R4 autoselect", rd_data_o, e);
            chk("R10 no reset in autoselect", {31'h0, mode_reset_o}, 0);
        end

        // R8/R9 query sweep across the length limit
        for (int wi = 0; wi < 128; wi++) begin
            rd(4, wi * 2, 0);
            chk((wi >= 82) ? "R8 query beyond limit" : "R9 query table", rd_data_o, {24'h0, query_exp(wi)});
        end
        rd(4, 16 * 2 + 1, 0);
        chk("R3 odd byte address maps to same index", rd_data_o, 32'h51);

        // R5 toggle only on busy reads
        status_rd("R5 first busy read");
        status_rd("R5 second busy read");
        repeat (5) @(negedge clk);
        status_rd("R5 idle cycles do not toggle");
        rd(0, 4, 0); rd(2, 0, 0); rd(4, 0, 0);
        status_rd("R5 other-mode reads do not toggle");

        // R6 program and erase start
        evt(1, 1, 0, 0, 0); st = 8'h7F;
        status_rd("R6 program bit7=1");
        status_rd("R5 toggle after program");
        evt(1, 0, 0, 0, 0); st = 8'hFF;
        status_rd("R6 program bit7=0");
        evt(0, 0, 1, 0, 0); st = 8'h00;
        status_rd("R6 erase start clears");
        evt(1, 1, 1, 1, 0); st = 8'h00;
        status_rd("R6 erase start wins");
        // read coincident with program: returns old value, no toggle
        @(negedge clk);
        mode_i = 3'd3; rd_en_i = 1'b1; prog_wr_i = 1'b1; prog_bit7_i = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_en_i = 0; prog_wr_i = 0;
        chk("R6 coincident read sees old status", rd_data_o, {24'h0, st});
        st = 8'h7F;
        status_rd("R6 event wins over toggle");

        // R7 erase completion
        evt(0, 0, 1, 0, 0); st = 8'h00;
        evt(0, 0, 0, 1, 1); st = st ^ 8'h80;
        chk("R7 cmpl_valid", {31'h0, cmpl_valid_o}, 1);
        chk("R7 cmpl_bypass set", {31'h0, cmpl_bypass_o}, 1);
        @(negedge clk);
        chk("R7 cmpl single pulse", {31'h0, cmpl_valid_o}, 0);
        status_rd("R7 poll bit inverted");
        status_rd("R7 then toggle");
        evt(0, 0, 0, 1, 0); st = st ^ 8'h80;
        chk("R7 cmpl to idle", {30'h0, cmpl_valid_o, cmpl_bypass_o}, 32'h2);
        status_rd("R7 second completion");

        // R10 undefined modes
        for (int md = 5; md < 8; md++) begin
            rd(md, 40 + md, 1);
            chk("R10 bad mode data", rd_data_o, arr_exp(40 + md, 1));
            chk("R10 mode_reset pulse", {31'h0, mode_reset_o}, 1);
            @(negedge clk);
            chk("R10 pulse ends", {31'h0, mode_reset_o}, 0);
        end
        rd(3, 0, 0);
        chk("R10 no reset in busy", {31'h0, mode_reset_o}, 0);

        done = 1'b1;
        summary();
    end
endmodule